// File: doc/BRIEF.md
# Bimodal Branch Predictor with Target Buffer

This block sits in the fetch stage of a 32-bit in-order pipeline with five stages and word-aligned instructions. It predicts, in the same cycle, the address to fetch next. A direct-mapped table of saturating counters gives the branch direction. A separately sized, direct-mapped, tagged target buffer gives the destination address. Both tables are indexed by low bits of the fetch PC, with the two byte-offset bits dropped. The counter width is a parameter and may be one bit or two bits.

The tables are written by two resolution ports. The decode port writes direct jumps, because their targets are known at decode. The execute port writes conditional branches and register-indirect jumps, because their outcome or target is known only at execute. Each resolution port receives the predicted next PC that travelled down the pipe with the instruction, and it raises a mispredict flag when the resolved next PC differs from that prediction. Flush control and decode are outside the block.

Top module: `bimodal_btb_predictor`

## Requirements
- R1: After reset every counter predicts not-taken (a two-bit counter starts at weak not-taken, value 01; a one-bit counter starts at 0) and no target-buffer entry is valid, so `f_next_pc` is `f_pc + 4` and `f_dir` is 0.
- R2: The counter for a PC is selected by PC[BHT_IDX+1:2]. PCs that differ only outside those bits share one counter.
- R3: A target-buffer lookup hits only when the entry at PC[BTB_IDX+2-1:2] is valid and its stored tag equals PC[31:BTB_IDX+2]. A PC with the same index and a different tag misses.
- R4: In two-bit mode the counter saturates at 00 and 11, `f_dir` is its upper bit, and two consecutive outcomes against the current prediction are needed to flip it.
- R5: `f_dir` comes from the counter alone. `f_next_pc` is the buffered target when the buffer hits and either the entry is marked unconditional or `f_dir` is 1; otherwise it is `f_pc + 4`.
- R6: A decode update writes the entry for `d_pc` with `d_target` and marks it unconditional, so the jump predicts its target whatever the counter holds. The update leaves the counters untouched.
- R7: An execute update with `x_cond`=1 moves the counter for `x_pc` one step toward `x_taken`. A taken outcome writes `x_target` into the buffer as a conditional entry, and a not-taken outcome leaves the buffer unchanged.
- R8: An execute update with `x_cond`=0 (register jump) writes `x_target` as an unconditional entry and leaves the counters unchanged.
- R9: When both ports write the same buffer slot in one cycle, the execute-port write is the one kept.
- R10: `x_mispredict` is 1 when `x_valid` is high and the resolved next PC (`x_pc + 4` for a not-taken conditional branch, otherwise `x_target`) differs from `x_pred_next`. `d_mispredict` is 1 when `d_valid` is high and `d_target` differs from `d_pred_next`. Both flags are combinational.
- R11: In one-bit mode the counter holds the last resolved outcome of its conditional branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_pc | input | 32 | Fetch PC |
| f_dir | output | 1 | Predicted direction from the counter table |
| f_next_pc | output | 32 | Predicted next fetch address |
| d_valid | input | 1 | Direct-jump resolution at decode |
| d_pc | input | 32 | PC of the jump |
| d_target | input | 32 | Jump target |
| d_pred_next | input | 32 | Next PC that was predicted for this jump |
| d_mispredict | output | 1 | Decode-stage misprediction |
| x_valid | input | 1 | Resolution at execute |
| x_pc | input | 32 | PC of the resolved instruction |
| x_cond | input | 1 | 1 = conditional branch, 0 = register jump |
| x_taken | input | 1 | Branch outcome (used when x_cond=1) |
| x_target | input | 32 | Resolved target |
| x_pred_next | input | 32 | Next PC that was predicted for this instruction |
| x_mispredict | output | 1 | Execute-stage misprediction |

## Verification
The hardest case to reach is a cycle in which both resolution ports write the same target-buffer slot. The execute-stage write must be the one kept, and the decode write must leave no trace. The bench drives both ports in one cycle with two PCs that share a buffer index but carry different tags. It then fetches each PC and expects the execute target for one and a miss for the other. Counter hysteresis is reached through runs of outcomes on one branch, and a one-bit instance sees the same runs. The alias case uses a PC that shares both the counter and the buffer index but has a different tag. It shows a shared direction together with a buffer miss.

// File: rtl/bimodal_btb_predictor.sv
module bimodal_btb_predictor #(
  parameter int CNT_BITS = 2,
  parameter int BHT_IDX  = 6,
  parameter int BTB_IDX  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] f_pc,
  output logic        f_dir,
  output logic [31:0] f_next_pc,
  input  logic        d_valid,
  input  logic [31:0] d_pc,
  input  logic [31:0] d_target,
  input  logic [31:0] d_pred_next,
  output logic        d_mispredict,
  input  logic        x_valid,
  input  logic [31:0] x_pc,
  input  logic        x_cond,
  input  logic        x_taken,
  input  logic [31:0] x_target,
  input  logic [31:0] x_pred_next,
  output logic        x_mispredict
);
  localparam int BHT_N = 1 << BHT_IDX;
  localparam int BTB_N = 1 << BTB_IDX;
  localparam int TAG_W = 30 - BTB_IDX;
  localparam logic [CNT_BITS-1:0] CNT_MAX  = {CNT_BITS{1'b1}};
  localparam logic [CNT_BITS-1:0] CNT_INIT = CNT_BITS'((1 << (CNT_BITS - 1)) - 1);

  logic [CNT_BITS-1:0] cnt     [BHT_N];
  logic                btb_v   [BTB_N];
  logic                btb_j   [BTB_N];
  logic [TAG_W-1:0]    btb_tag [BTB_N];
  logic [31:0]         btb_tgt [BTB_N];

  wire [BHT_IDX-1:0] f_bi = f_pc[BHT_IDX+1:2];
  wire [BHT_IDX-1:0] x_bi = x_pc[BHT_IDX+1:2];
  wire [BTB_IDX-1:0] f_ti = f_pc[BTB_IDX+1:2];
  wire [BTB_IDX-1:0] d_ti = d_pc[BTB_IDX+1:2];
  wire [BTB_IDX-1:0] x_ti = x_pc[BTB_IDX+1:2];
  wire unused_low = ^d_pc[1:0];

  wire f_hit = btb_v[f_ti] && (btb_tag[f_ti] == f_pc[31:BTB_IDX+2]);

  assign f_dir     = cnt[f_bi][CNT_BITS-1];
  assign f_next_pc = (f_hit && (btb_j[f_ti] || f_dir)) ? btb_tgt[f_ti] : f_pc + 32'd4;

  wire        x_wr  = x_valid && (!x_cond || x_taken);
  wire [31:0] x_res = (x_cond && !x_taken) ? x_pc + 32'd4 : x_target;

  assign x_mispredict = x_valid && (x_res != x_pred_next);
  assign d_mispredict = d_valid && (d_target != d_pred_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BHT_N; i++) cnt[i] <= CNT_INIT;
    end else if (x_valid && x_cond) begin
      if (x_taken && cnt[x_bi] != CNT_MAX)
        cnt[x_bi] <= cnt[x_bi] + CNT_BITS'(1);
      else if (!x_taken && cnt[x_bi] != '0)
        cnt[x_bi] <= cnt[x_bi] - CNT_BITS'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BTB_N; i++) begin
        btb_v[i]   <= 1'b0;
        btb_j[i]   <= 1'b0;
        btb_tag[i] <= '0;
        btb_tgt[i] <= '0;
      end
    end else begin
      if (d_valid) begin
        btb_v[d_ti]   <= 1'b1;
        btb_j[d_ti]   <= 1'b1;
        btb_tag[d_ti] <= d_pc[31:BTB_IDX+2];
        btb_tgt[d_ti] <= d_target;
      end
      if (x_wr) begin
        btb_v[x_ti]   <= 1'b1;
        btb_j[x_ti]   <= !x_cond;
        btb_tag[x_ti] <= x_pc[31:BTB_IDX+2];
        btb_tgt[x_ti] <= x_target;
      end
    end
  end
endmodule

module bimodal_btb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] f_pc,
  input logic        f_dir,
  input logic [31:0] f_next_pc,
  input logic        d_valid,
  input logic [31:0] d_pc,
  input logic [31:0] d_target,
  input logic        d_mispredict,
  input logic        x_valid,
  input logic [31:0] x_pc,
  input logic        x_cond,
  input logic        x_taken,
  input logic [31:0] x_target,
  input logic        x_mispredict
);
  AST_DEC_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pc == $past(d_pc) && $past(d_valid && !x_valid)) |-> f_next_pc == $past(d_target)); // R6

  AST_REG_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pc == $past(x_pc) && $past(x_valid && !x_cond)) |-> f_next_pc == $past(x_target)); // R8

  AST_TAKEN_KEEPS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pc == $past(f_pc) && $past(x_valid && x_cond && x_taken && x_pc == f_pc && f_dir)) |-> f_dir); // R4

  AST_NT_KEEPS_NT: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pc == $past(f_pc) && $past(x_valid && x_cond && !x_taken && x_pc == f_pc && !f_dir)) |-> !f_dir); // R4

  AST_XMISP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    x_mispredict |-> x_valid); // R10

  AST_DMISP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    d_mispredict |-> d_valid); // R10
endmodule

bind bimodal_btb_predictor bimodal_btb_checker u_chk (.*);

// File: tb/sim_bimodal_btb_predictor.sv
`timescale 1ns/1ps
module sim_bimodal_btb_predictor;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [31:0] f_pc = 0, d_pc = 0, d_target = 0, d_pred_next = 0;
  logic [31:0] x_pc = 0, x_target = 0, x_pred_next = 0;
  logic d_valid = 0, x_valid = 0, x_cond = 0, x_taken = 0;
  logic f_dir, d_misp, x_misp, f_dir1, d_misp1, x_misp1;
  logic [31:0] f_next, f_next1;

  bimodal_btb_predictor #(.CNT_BITS(2)) u0 (
    .clk, .rst_n, .f_pc, .f_dir(f_dir), .f_next_pc(f_next),
    .d_valid, .d_pc, .d_target, .d_pred_next, .d_mispredict(d_misp),
    .x_valid, .x_pc, .x_cond, .x_taken, .x_target, .x_pred_next, .x_mispredict(x_misp));

  bimodal_btb_predictor #(.CNT_BITS(1)) u1 (
    .clk, .rst_n, .f_pc, .f_dir(f_dir1), .f_next_pc(f_next1),
    .d_valid, .d_pc, .d_target, .d_pred_next, .d_mispredict(d_misp1),
    .x_valid, .x_pc, .x_cond, .x_taken, .x_target, .x_pred_next, .x_mispredict(x_misp1));

  typedef struct { int sel; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int nchk = 0, nerr = 0;
  bit done = 0;

  function automatic void expect_v(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = f_next;
        1: act = {31'd0, f_dir};
        2: act = {31'd0, f_dir1};
        3: act = f_next1;
        4: act = {31'd0, x_misp};
        default: act = {31'd0, d_misp};
      endcase
      nchk++;
      if (act !== it.exp) begin
        nerr++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic probe(input [31:0] pc, input [31:0] nx, input bit dir, input bit dir1, input string req);
    f_pc = pc;
    expect_v(0, nx, req);
    expect_v(1, {31'd0, dir}, req);
    expect_v(2, {31'd0, dir1}, req);
    cyc();
  endtask

  task automatic xupd(input [31:0] pc, input bit cond, input bit tk, input [31:0] tgt,
                      input [31:0] pred, input bit misp, input string req);
    x_valid = 1; x_pc = pc; x_cond = cond; x_taken = tk; x_target = tgt; x_pred_next = pred;
    expect_v(4, {31'd0, misp}, req);
    cyc();
    x_valid = 0;
  endtask

  task automatic dupd(input [31:0] pc, input [31:0] tgt, input [31:0] pred, input bit misp, input string req);
    d_valid = 1; d_pc = pc; d_target = tgt; d_pred_next = pred;
    expect_v(5, {31'd0, misp}, req);
    cyc();
    d_valid = 0;
  endtask

  localparam logic [31:0] A = 32'h0000_1040;

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    probe(32'h100, 32'h104, 0, 0, "R1");
    probe(A, A + 4, 0, 0, "R1");
    // R7/R10: taken, weak NT -> weak T, buffer written
    xupd(A, 1, 1, 32'h1000, A + 4, 1, "R10");
    probe(A, 32'h1000, 1, 1, "R7");
    xupd(A, 1, 1, 32'h1000, 32'h1000, 0, "R10");
    // not taken with a stray target: buffer must keep 0x1000
    xupd(A, 1, 0, 32'h1234, 32'h1000, 1, "R10");
    probe(A, 32'h1000, 1, 0, "R4");   // R4 strong->weak still taken; R11 one-bit follows outcome; R7 buffer untouched
    xupd(A, 1, 0, 32'h1234, 32'h1000, 1, "R10");
    probe(A, A + 4, 0, 0, "R4");      // R4 flip after two; R5 hit but not taken
    xupd(A, 1, 0, 32'h1234, A + 4, 0, "R10");
    xupd(A, 1, 1, 32'h1000, A + 4, 1, "R10");
    probe(A, A + 4, 0, 1, "R4");      // R4 saturation at 00, one taken not enough; R11
    f_pc = A; expect_v(3, 32'h1000, "R11"); cyc();
    // R2 alias on counter, R3 tag miss
    probe(A + 32'h100, A + 32'h104, 0, 1, "R2");
    f_pc = A + 32'h100; expect_v(3, A + 32'h104, "R3"); cyc();
    // R6 decode jump
    dupd(32'h2000, 32'h3000, 32'h2004, 1, "R10");
    probe(32'h2000, 32'h3000, 0, 0, "R6");
    dupd(32'h2000, 32'h3000, 32'h3000, 0, "R10");
    // R8 register jump
    xupd(32'h2404, 0, 0, 32'h5550, 32'h2408, 1, "R10");
    probe(32'h2404, 32'h5550, 0, 0, "R8");
    // R9 same-slot collision
    d_valid = 1; d_pc = 32'h6008; d_target = 32'h7000; d_pred_next = 32'h600C;
    x_valid = 1; x_pc = 32'h8008; x_cond = 0; x_taken = 0; x_target = 32'h9000; x_pred_next = 32'h9000;
    expect_v(4, 0, "R10"); expect_v(5, 1, "R10");
    cyc();
    d_valid = 0; x_valid = 0;
    probe(32'h8008, 32'h9000, 0, 0, "R9");
    probe(32'h6008, 32'h600C, 0, 0, "R9");
    cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule